// File: doc/BRIEF.md
# Operand-Wakeup Issue Queue for an Out-of-Order ALU

This block sits between instruction issue and a single arithmetic unit in an out-of-order core. It holds a few decoded instructions whose source operands may still be outstanding. Each operand is held either as a value or as the reorder-buffer tag of the instruction that will produce it. The block watches the shared result bus and replaces a pending tag with the broadcast value when the tags match.

In every cycle, the block picks one slot whose operands are both resolved and hands it to its own execution unit. That unit is a registered stage of simple integer operations. Its result and destination tag leave on the result port, to be placed on the shared bus by an arbiter outside this block.

A register-write instruction whose source is still pending uses the move-A operation. It waits in a slot like any arithmetic instruction. A flush empties the queue.

Top module: `resv_station`

## Requirements
- R1: The operation code selects the result as follows: 0 gives a+b, 1 gives a-b, 2 gives a AND b, 3 gives a OR b, 4 gives a XOR b, 5 gives a shifted left by b[4:0], 6 gives a shifted right logically by b[4:0], and 7 passes a through unchanged. All arithmetic is modulo 2^32.
- R2: An instruction accepted with both operands ready appears on the result port exactly two clock edges after the accepting edge. Its result is valid for one cycle per dispatch, and the result port is idle when nothing was dispatched.
- R3: A stored operand that is waiting on tag T takes the bus value and becomes ready when the bus is valid with tag T. A bus broadcast with any other tag leaves it waiting.
- R4: When a bus broadcast with tag T arrives in the same cycle as an instruction is accepted with an operand waiting on T, that operand is stored already holding the broadcast value.
- R5: A slot is dispatched only when both of its operands hold values. A slot with one operand still pending never produces a result.
- R6: At most one slot dispatches per cycle, and it is the lowest-index ready slot. New instructions fill the lowest-index free slot.
- R7: `full` is 1 exactly when every slot is occupied. An issue request made while `full` is 1 is dropped and never produces a result.
- R8: A flush empties every slot and cancels the result in flight. A broadcast after the flush produces no result, and `full` reads 0.
- R9: Each result carries the destination tag that was supplied with its instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empties all slots and cancels the in-flight result |
| issue_valid | input | 1 | Issue request |
| issue_op | input | 3 | Operation code (see R1) |
| issue_a_rdy | input | 1 | Operand A holds a value |
| issue_a_val | input | 32 | Operand A value |
| issue_a_tag | input | 4 | Producer tag of operand A |
| issue_b_rdy | input | 1 | Operand B holds a value |
| issue_b_val | input | 32 | Operand B value |
| issue_b_tag | input | 4 | Producer tag of operand B |
| issue_dst | input | 4 | Destination reorder-buffer tag |
| full | output | 1 | All slots occupied |
| bus_valid | input | 1 | Shared result bus valid |
| bus_tag | input | 4 | Shared result bus tag |
| bus_val | input | 32 | Shared result bus value |
| res_valid | output | 1 | Result valid |
| res_tag | output | 4 | Result destination tag |
| res_val | output | 32 | Result value |

## Verification
Two events can coincide: an instruction can be inserted in the same cycle that the bus broadcasts the tag it is waiting on. The bench provokes this by driving the issue request and the broadcast on the same clock edge, for operand A and, separately, for operand B. It then requires the result to appear with the two-edge latency of an instruction that had arrived ready, carrying the broadcast value. A second coincidence is one broadcast waking several slots at once; the order and timing of their results reveal the lowest-index choice and the one-per-cycle limit.

// File: rtl/rs_pkg.sv
package rs_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_AND  = 3'd2,
    OP_OR   = 3'd3,
    OP_XOR  = 3'd4,
    OP_SLL  = 3'd5,
    OP_SRL  = 3'd6,
    OP_MOVA = 3'd7
  } rs_op_e;
endpackage

// File: rtl/rs_pick.sv
module rs_pick #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx,
  output logic [N-1:0]  gnt
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
    any = |req;
    gnt = any ? (N'(1) << idx) : '0;
  end
endmodule

// File: rtl/rs_slot.sv
module rs_slot #(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 4,
  parameter int OP_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              load,
  input  logic              clear,
  input  logic [OP_W-1:0]   ld_op,
  input  logic              ld_a_rdy,
  input  logic [DATA_W-1:0] ld_a_val,
  input  logic [TAG_W-1:0]  ld_a_tag,
  input  logic              ld_b_rdy,
  input  logic [DATA_W-1:0] ld_b_val,
  input  logic [TAG_W-1:0]  ld_b_tag,
  input  logic [TAG_W-1:0]  ld_dst,
  input  logic              bus_valid,
  input  logic [TAG_W-1:0]  bus_tag,
  input  logic [DATA_W-1:0] bus_val,
  output logic              vld,
  output logic              rdy,
  output logic [OP_W-1:0]   op,
  output logic [DATA_W-1:0] a_val,
  output logic [DATA_W-1:0] b_val,
  output logic [TAG_W-1:0]  dst
);
  logic             a_rdy, b_rdy;
  logic [TAG_W-1:0] a_tag, b_tag;

  function automatic logic tag_hit(input logic have, input logic [TAG_W-1:0] want,
                                   input logic bv, input logic [TAG_W-1:0] bt);
    return !have && bv && (want == bt);
  endfunction

  logic ld_hit_a, ld_hit_b, st_hit_a, st_hit_b;
  assign ld_hit_a = tag_hit(ld_a_rdy, ld_a_tag, bus_valid, bus_tag);
  assign ld_hit_b = tag_hit(ld_b_rdy, ld_b_tag, bus_valid, bus_tag);
  assign st_hit_a = tag_hit(a_rdy, a_tag, bus_valid, bus_tag);
  assign st_hit_b = tag_hit(b_rdy, b_tag, bus_valid, bus_tag);

  assign rdy = vld && a_rdy && b_rdy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld   <= 1'b0;
      a_rdy <= 1'b0;
      b_rdy <= 1'b0;
      op    <= '0;
      a_val <= '0;
      b_val <= '0;
      a_tag <= '0;
      b_tag <= '0;
      dst   <= '0;
    end else if (flush) begin
      vld <= 1'b0;
    end else if (load) begin
      vld   <= 1'b1;
      op    <= ld_op;
      dst   <= ld_dst;
      a_tag <= ld_a_tag;
      b_tag <= ld_b_tag;
      a_rdy <= ld_a_rdy | ld_hit_a;
      b_rdy <= ld_b_rdy | ld_hit_b;
      a_val <= ld_hit_a ? bus_val : ld_a_val;
      b_val <= ld_hit_b ? bus_val : ld_b_val;
    end else if (clear) begin
      vld <= 1'b0;
    end else if (vld) begin
      if (st_hit_a) begin
        a_rdy <= 1'b1;
        a_val <= bus_val;
      end
      if (st_hit_b) begin
        b_rdy <= 1'b1;
        b_val <= bus_val;
      end
    end
  end
endmodule

// File: rtl/rs_exec.sv
module rs_exec #(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 4,
  parameter int OP_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              go,
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [TAG_W-1:0]  dst,
  output logic              res_valid,
  output logic [TAG_W-1:0]  res_tag,
  output logic [DATA_W-1:0] res_val
);
  localparam int SHW = $clog2(DATA_W);

  function automatic logic [DATA_W-1:0] alu_eval(input logic [OP_W-1:0] code,
                                                 input logic [DATA_W-1:0] x,
                                                 input logic [DATA_W-1:0] y);
    case (rs_pkg::rs_op_e'(code))
      rs_pkg::OP_ADD:  return x + y;
      rs_pkg::OP_SUB:  return x - y;
      rs_pkg::OP_AND:  return x & y;
      rs_pkg::OP_OR:   return x | y;
      rs_pkg::OP_XOR:  return x ^ y;
      rs_pkg::OP_SLL:  return x << y[SHW-1:0];
      rs_pkg::OP_SRL:  return x >> y[SHW-1:0];
      default:         return x;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_tag   <= '0;
      res_val   <= '0;
    end else begin
      res_valid <= go && !flush;
      if (go) begin
        res_tag <= dst;
        res_val <= alu_eval(op, a, b);
      end
    end
  end
endmodule

// File: rtl/resv_station.sv
module resv_station #(
  parameter int NUM_SLOTS = 4,
  parameter int DATA_W    = 32,
  parameter int TAG_W     = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   flush,
  input  logic                   issue_valid,
  input  logic [rs_pkg::OP_W-1:0] issue_op,
  input  logic                   issue_a_rdy,
  input  logic [DATA_W-1:0]      issue_a_val,
  input  logic [TAG_W-1:0]       issue_a_tag,
  input  logic                   issue_b_rdy,
  input  logic [DATA_W-1:0]      issue_b_val,
  input  logic [TAG_W-1:0]       issue_b_tag,
  input  logic [TAG_W-1:0]       issue_dst,
  output logic                   full,
  input  logic                   bus_valid,
  input  logic [TAG_W-1:0]       bus_tag,
  input  logic [DATA_W-1:0]      bus_val,
  output logic                   res_valid,
  output logic [TAG_W-1:0]       res_tag,
  output logic [DATA_W-1:0]      res_val
);
  localparam int OP_W  = rs_pkg::OP_W;
  localparam int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

  logic [NUM_SLOTS-1:0] slot_vld, slot_rdy, slot_load, disp_gnt, free_gnt;
  logic [OP_W-1:0]      s_op  [NUM_SLOTS];
  logic [DATA_W-1:0]    s_a   [NUM_SLOTS];
  logic [DATA_W-1:0]    s_b   [NUM_SLOTS];
  logic [TAG_W-1:0]     s_dst [NUM_SLOTS];

  logic             free_any, accept, disp_fire;
  logic [IDX_W-1:0] free_idx, disp_idx;
  logic [OP_W-1:0]  disp_op;
  logic [DATA_W-1:0] disp_a, disp_b;
  logic [TAG_W-1:0] disp_dst;

  rs_pick #(.N(NUM_SLOTS), .IW(IDX_W)) u_alloc (
    .req(~slot_vld), .any(free_any), .idx(free_idx), .gnt(free_gnt)
  );

  assign full      = !free_any;
  assign accept    = issue_valid && free_any;
  assign slot_load = accept ? free_gnt : '0;

  rs_pick #(.N(NUM_SLOTS), .IW(IDX_W)) u_disp (
    .req(slot_rdy), .any(disp_fire), .idx(disp_idx), .gnt(disp_gnt)
  );

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    rs_slot #(.DATA_W(DATA_W), .TAG_W(TAG_W), .OP_W(OP_W)) u_slot (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .load(slot_load[g]), .clear(disp_gnt[g]),
      .ld_op(issue_op),
      .ld_a_rdy(issue_a_rdy), .ld_a_val(issue_a_val), .ld_a_tag(issue_a_tag),
      .ld_b_rdy(issue_b_rdy), .ld_b_val(issue_b_val), .ld_b_tag(issue_b_tag),
      .ld_dst(issue_dst),
      .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_val(bus_val),
      .vld(slot_vld[g]), .rdy(slot_rdy[g]),
      .op(s_op[g]), .a_val(s_a[g]), .b_val(s_b[g]), .dst(s_dst[g])
    );
  end

  assign disp_op  = s_op[disp_idx];
  assign disp_a   = s_a[disp_idx];
  assign disp_b   = s_b[disp_idx];
  assign disp_dst = s_dst[disp_idx];

  rs_exec #(.DATA_W(DATA_W), .TAG_W(TAG_W), .OP_W(OP_W)) u_exec (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .go(disp_fire), .op(disp_op), .a(disp_a), .b(disp_b), .dst(disp_dst),
    .res_valid(res_valid), .res_tag(res_tag), .res_val(res_val)
  );
endmodule

// File: rtl/rs_checker.sv
module rs_checker #(
  parameter int N     = 4,
  parameter int IW    = 2,
  parameter int TAG_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic [N-1:0]     slot_vld,
  input logic [N-1:0]     slot_rdy,
  input logic             disp_fire,
  input logic [IW-1:0]    disp_idx,
  input logic [TAG_W-1:0] disp_dst,
  input logic             accept,
  input logic             full,
  input logic             res_valid,
  input logic [TAG_W-1:0] res_tag
);
  logic [N-1:0] below_mask;
  assign below_mask = (N'(1) << disp_idx) - N'(1);

  assert_dispatch_eligible_R5: assert property (@(posedge clk) disable iff (!rst_n)
    disp_fire |-> (slot_vld[disp_idx] && slot_rdy[disp_idx]));

  assert_lowest_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    disp_fire |-> ((slot_rdy & below_mask) == '0));

  assert_ready_not_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|slot_rdy) |-> disp_fire);

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> !full);

  assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (slot_vld == '0 && !res_valid));

  assert_result_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_fire && !flush) |=> (res_valid && res_tag == $past(disp_dst)));

  assert_result_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!disp_fire || flush) |=> !res_valid);
endmodule

bind resv_station rs_checker #(.N(NUM_SLOTS), .IW(IDX_W), .TAG_W(TAG_W)) u_rs_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush),
  .slot_vld(slot_vld), .slot_rdy(slot_rdy),
  .disp_fire(disp_fire), .disp_idx(disp_idx), .disp_dst(disp_dst),
  .accept(accept), .full(full),
  .res_valid(res_valid), .res_tag(res_tag)
);

// File: tb/tb_resv_station.sv
module tb_resv_station;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        issue_valid = 1'b0;
  logic [2:0]  issue_op = '0;
  logic        issue_a_rdy = 1'b0, issue_b_rdy = 1'b0;
  logic [31:0] issue_a_val = '0, issue_b_val = '0;
  logic [3:0]  issue_a_tag = '0, issue_b_tag = '0, issue_dst = '0;
  logic        full;
  logic        bus_valid = 1'b0;
  logic [3:0]  bus_tag = '0;
  logic [31:0] bus_val = '0;
  logic        res_valid;
  logic [3:0]  res_tag;
  logic [31:0] res_val;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  resv_station dut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .issue_valid(issue_valid), .issue_op(issue_op),
    .issue_a_rdy(issue_a_rdy), .issue_a_val(issue_a_val), .issue_a_tag(issue_a_tag),
    .issue_b_rdy(issue_b_rdy), .issue_b_val(issue_b_val), .issue_b_tag(issue_b_tag),
    .issue_dst(issue_dst), .full(full),
    .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_val(bus_val),
    .res_valid(res_valid), .res_tag(res_tag), .res_val(res_val)
  );

  function automatic logic [31:0] model(input logic [2:0] op, input logic [31:0] a,
                                        input logic [31:0] b);
    logic [31:0] r;
    int sh;
    sh = int'(b & 32'd31);
    r = a;
    if (op == 3'd0) r = a + b;
    if (op == 3'd1) r = a + (~b) + 32'd1;
    if (op == 3'd2) r = ~(~a | ~b);
    if (op == 3'd3) r = ~(~a & ~b);
    if (op == 3'd4) r = (a | b) & ~(a & b);
    if (op == 3'd5) for (int k = 0; k < sh; k++) r = {r[30:0], 1'b0};
    if (op == 3'd6) for (int k = 0; k < sh; k++) r = {1'b0, r[31:1]};
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic put(input logic [2:0] op, input logic ar, input logic [31:0] av,
                     input logic [3:0] at, input logic br, input logic [31:0] bv,
                     input logic [3:0] bt, input logic [3:0] d);
    issue_valid = 1'b1; issue_op = op;
    issue_a_rdy = ar; issue_a_val = av; issue_a_tag = at;
    issue_b_rdy = br; issue_b_val = bv; issue_b_tag = bt;
    issue_dst = d;
  endtask

  task automatic issue(input logic [2:0] op, input logic ar, input logic [31:0] av,
                       input logic [3:0] at, input logic br, input logic [31:0] bv,
                       input logic [3:0] bt, input logic [3:0] d);
    put(op, ar, av, at, br, bv, bt, d);
    @(negedge clk);
    issue_valid = 1'b0;
  endtask

  task automatic bcast(input logic [3:0] t, input logic [31:0] v);
    bus_valid = 1'b1; bus_tag = t; bus_val = v;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic expect_res(input string req, input logic [3:0] t, input logic [31:0] v);
    chk(res_valid === 1'b1, req, "res_valid", 32'(res_valid), 32'd1);
    chk(res_tag === t, "R9", "res_tag", 32'(res_tag), 32'(t));
    chk(res_val === v, req, "res_val", res_val, v);
  endtask

  task automatic expect_quiet(input string req, input int cycles);
    for (int c = 0; c < cycles; c++) begin
      chk(res_valid === 1'b0, req, "no result", 32'(res_valid), 32'd0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] avals [4];
    logic [31:0] bvals [4];
    avals[0] = 32'h0; avals[1] = 32'h1; avals[2] = 32'h8000_0001; avals[3] = 32'hFFFF_FFFF;
    bvals[0] = 32'h0; bvals[1] = 32'h3; bvals[2] = 32'hF0F0_F0FF; bvals[3] = 32'h1F;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(full === 1'b0, "R7", "full after reset", 32'(full), 32'd0);
    chk(res_valid === 1'b0, "R2", "res_valid after reset", 32'(res_valid), 32'd0);

    // R1 / R2: sweep all operations over the operand set, exact latency
    for (int op = 0; op < 8; op++)
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++) begin
          issue(3'(op), 1'b1, avals[i], 4'd0, 1'b1, bvals[j], 4'd0, 4'(op + i));
          chk(res_valid === 1'b0, "R2", "early result", 32'(res_valid), 32'd0);
          @(negedge clk);
          expect_res("R1", 4'(op + i), model(3'(op), avals[i], bvals[j]));
          @(negedge clk);
        end

    // R6: priority among slots woken together; R3 unrelated tag stays waiting
    issue(3'd0, 1'b0, 32'd0, 4'd5, 1'b1, 32'd1, 4'd0, 4'd1);
    issue(3'd1, 1'b0, 32'd0, 4'd6, 1'b1, 32'd1, 4'd0, 4'd2);
    issue(3'd0, 1'b0, 32'd0, 4'd5, 1'b1, 32'd2, 4'd0, 4'd3);
    expect_quiet("R5", 2);
    bcast(4'd5, 32'd10);
    chk(res_valid === 1'b0, "R6", "result before dispatch", 32'(res_valid), 32'd0);
    @(negedge clk);
    expect_res("R6", 4'd1, 32'd11);
    @(negedge clk);
    expect_res("R6", 4'd3, 32'd12);
    @(negedge clk);
    expect_quiet("R3", 2);
    bcast(4'd6, 32'd3);
    @(negedge clk);
    expect_res("R3", 4'd2, 32'd2);
    @(negedge clk);

    // R7: fill, blocked issue, drain in slot order
    for (int k = 0; k < 4; k++)
      issue(3'd0, 1'b0, 32'd0, 4'd9, 1'b1, 32'(k + 1), 4'd0, 4'(k + 1));
    chk(full === 1'b1, "R7", "full when all slots used", 32'(full), 32'd1);
    put(3'd0, 1'b1, 32'd100, 4'd0, 1'b1, 32'd100, 4'd0, 4'd15);
    @(negedge clk);
    @(negedge clk);
    issue_valid = 1'b0;
    chk(full === 1'b1, "R7", "full held", 32'(full), 32'd1);
    bcast(4'd9, 32'd7);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      expect_res("R6", 4'(k + 1), 32'(8 + k));
      if (k == 0) chk(full === 1'b0, "R7", "full drops", 32'(full), 32'd0);
    end
    @(negedge clk);
    expect_quiet("R7", 3);

    // R4: bus hit in the insertion cycle, operand A then operand B
    put(3'd0, 1'b0, 32'd0, 4'd3, 1'b1, 32'd2, 4'd0, 4'd7);
    bus_valid = 1'b1; bus_tag = 4'd3; bus_val = 32'd40;
    @(negedge clk);
    issue_valid = 1'b0; bus_valid = 1'b0;
    chk(res_valid === 1'b0, "R4", "early result", 32'(res_valid), 32'd0);
    @(negedge clk);
    expect_res("R4", 4'd7, 32'd42);
    @(negedge clk);
    put(3'd1, 1'b1, 32'd100, 4'd0, 1'b0, 32'd0, 4'd8, 4'd6);
    bus_valid = 1'b1; bus_tag = 4'd8; bus_val = 32'd1;
    @(negedge clk);
    issue_valid = 1'b0; bus_valid = 1'b0;
    @(negedge clk);
    expect_res("R4", 4'd6, 32'd99);
    @(negedge clk);

    // R5 / R3: one operand pending, mismatching tag ignored
    issue(3'd4, 1'b1, 32'hFF, 4'd0, 1'b0, 32'd0, 4'd13, 4'd4);
    bcast(4'd12, 32'h0F);
    expect_quiet("R5", 3);
    bcast(4'd13, 32'h0F);
    @(negedge clk);
    expect_res("R3", 4'd4, 32'hF0);
    @(negedge clk);

    // R8: flush empties the queue
    for (int k = 0; k < 4; k++)
      issue(3'd0, 1'b0, 32'd0, 4'd12, 1'b1, 32'd1, 4'd0, 4'(k + 8));
    chk(full === 1'b1, "R8", "full before flush", 32'(full), 32'd1);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    chk(full === 1'b0, "R8", "full after flush", 32'(full), 32'd0);
    bcast(4'd12, 32'd5);
    expect_quiet("R8", 4);

    // R8: flush cancels a result in flight
    issue(3'd0, 1'b1, 32'd1, 4'd0, 1'b1, 32'd1, 4'd0, 4'd2);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    expect_quiet("R8", 3);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule